// File: doc/BRIEF.md
# Two-Trit Ternary Adder-Subtractor

This block adds or subtracts two unsigned ternary numbers of `NTRITS` digits, two by default. A mode trit picks the operation. Mode 2 gives X+Y. Mode 1 gives X−Y, computed in radix-3 complement: each digit of Y is replaced by two minus that digit, and a carry of 1 enters the lowest digit. The sum then passes through a ripple of ternary full adders. Each full adder is a pair of half adders, and the maximum of their two carries forms its carry out. The block returns the result digits and the final carry trit.

Each trit is carried on two wires. Code 00 means 0, 01 means 1 and 10 means 2. Code 11 is not a trit. Mode 0 is reserved. If the mode is reserved or illegal, or if any operand digit uses code 11, the block drives zero on all data outputs and raises an error flag. The block is purely combinational, so its outputs follow its inputs within the same cycle.

Top module: `tern_addsub`

## Requirements
- R1: Trits use code 00=0, 01=1, 10=2, with digit i at bits [2i+1:2i] (digit 0 least significant). Outputs never show code 11.
- R2: With mode 10 (2) and legal operands, the result equals (X+Y) mod 3^NTRITS.
- R3: With mode 2, the carry trit is 1 when X+Y reaches 3^NTRITS and 0 otherwise. It is never 2.
- R4: With mode 01 (1) and legal operands, the result equals (X−Y+3^NTRITS) mod 3^NTRITS.
- R5: With mode 1, the carry trit is 1 when X≥Y and 0 when X<Y. The missing carry is the borrow.
- R6: With mode 1 and X equal to Y, the result is all zero and the carry trit is 1.
- R7: Mode 00 (0) or mode 11 sets the error flag and forces the result and carry to zero.
- R8: A code 11 in any digit of X or Y sets the error flag and forces the result and carry to zero, whatever the mode.
- R9: With a legal mode of 1 or 2 and legal operands, the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xIn | input | 2*NTRITS | First operand, one 2-bit code per trit |
| yIn | input | 2*NTRITS | Second operand (subtrahend in mode 1) |
| modeIn | input | 2 | Mode trit: 2 add, 1 subtract |
| resOut | output | 2*NTRITS | Sum or difference digits |
| carryOut | output | 2 | Final carry trit |
| errOut | output | 1 | Reserved mode or illegal digit code seen |

## Verification
Two behaviours can meet in one input pattern. In the first, the carry chain produces a result that wraps to zero while the carry out is set. This is provoked by subtracting equal operands, or by adding operands whose total is exactly nine. The output must then be all-zero digits with a carry of 1. In the second, the error gating masks an arithmetic result. This is provoked by giving a pair that would carry together with an illegal digit code or a reserved mode, and it is judged by seeing zero outputs with the flag set. Every legal operand pair is swept in both modes and compared against integer arithmetic.

// File: rtl/tern_addsub_pkg.sv
package tern_addsub_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b01;
  localparam trit_t TRIT_TWO  = 2'b10;
  localparam trit_t TRIT_BAD  = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic doSub;     // complement Y digits
    logic carryIn;   // inject 1 into the low digit
    logic clearOut;  // force outputs to zero
  } ctrlStrobes_t;

  // standard ternary inversion: 2 - t
  function automatic trit_t tritInvert(trit_t t);
    case (t)
      TRIT_ZERO: return TRIT_TWO;
      TRIT_TWO:  return TRIT_ZERO;
      default:   return t;
    endcase
  endfunction

  function automatic trit_t tritMax(trit_t a, trit_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tern_half_adder.sv
module tern_half_adder
  import tern_addsub_pkg::*;
(
  input  trit_t aIn,
  input  trit_t bIn,
  output trit_t sumOut,
  output trit_t carryOut
);
  logic [2:0] total;

  always_comb begin
    total = {1'b0, aIn} + {1'b0, bIn};
    if (total >= 3'd3) begin
      sumOut   = trit_t'(total - 3'd3);
      carryOut = TRIT_ONE;
    end else begin
      sumOut   = trit_t'(total);
      carryOut = TRIT_ZERO;
    end
  end
endmodule

// File: rtl/tern_full_adder.sv
module tern_full_adder
  import tern_addsub_pkg::*;
(
  input  trit_t aIn,
  input  trit_t bIn,
  input  trit_t cIn,
  output trit_t sumOut,
  output trit_t carryOut
);
  trit_t partSum;
  trit_t carryA;
  trit_t carryB;

  tern_half_adder uHalfA (
    .aIn(aIn), .bIn(bIn), .sumOut(partSum), .carryOut(carryA)
  );
  tern_half_adder uHalfB (
    .aIn(partSum), .bIn(cIn), .sumOut(sumOut), .carryOut(carryB)
  );

  assign carryOut = tritMax(carryA, carryB);

  // digit weight balance of the two half adders plus max-merge (R2)
  always_comb begin
    if (aIn != TRIT_BAD && bIn != TRIT_BAD && cIn != TRIT_BAD && cIn != TRIT_TWO)
      assert_digit_balance_R2: assert (int'(aIn) + int'(bIn) + int'(cIn)
                                       == int'(sumOut) + 3 * int'(carryOut))
        else $error("full adder digit balance broken");
  end
endmodule

// File: rtl/tern_addsub_ctrl.sv
module tern_addsub_ctrl
  import tern_addsub_pkg::*;
#(
  parameter int NTRITS = 2,
  localparam int VecW = 2 * NTRITS
) (
  input  logic [VecW-1:0] xIn,
  input  logic [VecW-1:0] yIn,
  input  trit_t           modeIn,
  output ctrlStrobes_t    strobes,
  output logic            errFlag
);
  logic operandBad;

  always_comb begin
    operandBad = 1'b0;
    for (int i = 0; i < NTRITS; i++) begin
      if (xIn[2*i +: 2] == TRIT_BAD || yIn[2*i +: 2] == TRIT_BAD)
        operandBad = 1'b1;
    end
  end

  always_comb begin
    strobes = '0;
    errFlag = 1'b0;
    if (operandBad) begin
      strobes.clearOut = 1'b1;
      errFlag          = 1'b1;
    end else begin
      case (modeIn)
        TRIT_TWO: ;
        TRIT_ONE: begin
          strobes.doSub   = 1'b1;
          strobes.carryIn = 1'b1;
        end
        default: begin
          strobes.clearOut = 1'b1;
          errFlag          = 1'b1;
        end
      endcase
    end
  end

  // a flagged error never starts a subtraction (R7)
  always_comb begin
    if (errFlag)
      assert_err_no_sub_R7: assert (!strobes.doSub && !strobes.carryIn)
        else $error("error state still drives subtract strobes");
  end
endmodule

// File: rtl/tern_addsub_dp.sv
module tern_addsub_dp
  import tern_addsub_pkg::*;
#(
  parameter int NTRITS = 2,
  localparam int VecW = 2 * NTRITS
) (
  input  logic [VecW-1:0] xIn,
  input  logic [VecW-1:0] yIn,
  input  ctrlStrobes_t    strobes,
  output logic [VecW-1:0] resOut,
  output trit_t           carryOut
);
  logic [VecW-1:0] yEff;
  logic [VecW-1:0] rawSum;
  logic [2*(NTRITS+1)-1:0] chain;

  assign chain[1:0] = strobes.carryIn ? TRIT_ONE : TRIT_ZERO;

  for (genvar i = 0; i < NTRITS; i++) begin : gDigit
    assign yEff[2*i +: 2] = strobes.doSub ? tritInvert(yIn[2*i +: 2]) : yIn[2*i +: 2];

    tern_full_adder uFull (
      .aIn     (xIn[2*i +: 2]),
      .bIn     (yEff[2*i +: 2]),
      .cIn     (chain[2*i +: 2]),
      .sumOut  (rawSum[2*i +: 2]),
      .carryOut(chain[2*(i+1) +: 2])
    );
  end

  assign resOut   = strobes.clearOut ? '0 : rawSum;
  assign carryOut = strobes.clearOut ? TRIT_ZERO : chain[2*NTRITS +: 2];
endmodule

// File: rtl/tern_addsub.sv
module tern_addsub
  import tern_addsub_pkg::*;
#(
  parameter int NTRITS = 2,
  localparam int VecW = 2 * NTRITS
) (
  input  logic [VecW-1:0] xIn,
  input  logic [VecW-1:0] yIn,
  input  logic [1:0]      modeIn,
  output logic [VecW-1:0] resOut,
  output logic [1:0]      carryOut,
  output logic            errOut
);
  ctrlStrobes_t strobes;

  tern_addsub_ctrl #(.NTRITS(NTRITS)) uCtrl (
    .xIn(xIn), .yIn(yIn), .modeIn(modeIn), .strobes(strobes), .errFlag(errOut)
  );

  tern_addsub_dp #(.NTRITS(NTRITS)) uDp (
    .xIn(xIn), .yIn(yIn), .strobes(strobes), .resOut(resOut), .carryOut(carryOut)
  );

  always_comb begin
    if (errOut)
      assert_err_zero_R8: assert (resOut == '0 && carryOut == TRIT_ZERO)
        else $error("error flag with nonzero outputs");
    assert_carry_binary_R3: assert (carryOut != TRIT_TWO && carryOut != TRIT_BAD)
      else $error("carry trit out of range");
    for (int i = 0; i < NTRITS; i++)
      assert_legal_code_R1: assert (resOut[2*i +: 2] != TRIT_BAD)
        else $error("illegal result code");
    if (!errOut && modeIn == TRIT_ONE && xIn == yIn)
      assert_equal_sub_R6: assert (resOut == '0 && carryOut == TRIT_ONE)
        else $error("equal operands did not cancel");
  end
endmodule

// File: tb/sim_tern_addsub.sv
module sim_tern_addsub;
  localparam int NT = 2;
  localparam int W = 2 * NT;
  localparam int MODV = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] xIn, yIn, resOut;
  logic [1:0] modeIn, carryOut;
  logic errOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tern_addsub #(.NTRITS(NT)) u0 (
    .xIn(xIn), .yIn(yIn), .modeIn(modeIn),
    .resOut(resOut), .carryOut(carryOut), .errOut(errOut)
  );

  function automatic logic [W-1:0] encNum(int n);
    logic [W-1:0] v;
    int r = n;
    for (int i = 0; i < NT; i++) begin
      v[2*i +: 2] = 2'(r % 3);
      r = r / 3;
    end
    return v;
  endfunction

  function automatic int decNum(logic [W-1:0] v);
    int n = 0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (v[2*i +: 2] == 2'b11) return -1;
      n = n * 3 + int'(v[2*i +: 2]);
    end
    return n;
  endfunction

  task automatic checkOne(input logic [W-1:0] x, input logic [W-1:0] y,
                          input logic [1:0] m, input string tag);
    int xv, yv, s;
    logic [W-1:0] expRes;
    logic [1:0] expCarry;
    logic expErr;
    @(negedge clk);
    xIn = x; yIn = y; modeIn = m;
    xv = decNum(x); yv = decNum(y);
    if (xv < 0 || yv < 0 || !(m == 2'b10 || m == 2'b01)) begin
      expRes = '0; expCarry = 2'b00; expErr = 1'b1;
    end else begin
      s = (m == 2'b10) ? xv + yv : xv - yv + MODV;
      expRes = encNum(s % MODV);
      expCarry = 2'(s / MODV);
      expErr = 1'b0;
    end
    @(posedge clk);
    #1;
    tests++;
    if (resOut !== expRes || carryOut !== expCarry || errOut !== expErr) begin
      fails++;
      $display("FAIL %s x=%b y=%b m=%b: got res=%b c=%b e=%b, expected res=%b c=%b e=%b",
               tag, x, y, m, resOut, carryOut, errOut, expRes, expCarry, expErr);
    end
    tests++;
    for (int i = 0; i < NT; i++) begin
      if (resOut[2*i +: 2] == 2'b11) begin
        fails++;
        $display("FAIL R1 digit %0d code: got %b expected a legal code", i, resOut[2*i +: 2]);
      end
    end
  endtask

  initial begin
    xIn = '0; yIn = '0; modeIn = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-phase pattern: reserved mode 0 with zero operands (R7)
    checkOne('0, '0, 2'b00, "R7 reset");
    // exhaustive add (R2 R3 R9) and subtract (R4 R5 R6 R9)
    for (int a = 0; a < MODV; a++)
      for (int b = 0; b < MODV; b++) begin
        checkOne(encNum(a), encNum(b), 2'b10, "R2 R3 R9 add");
        checkOne(encNum(a), encNum(b), 2'b01,
                 (a == b) ? "R6 equal sub" : (a < b) ? "R5 borrow" : "R4 sub");
      end
    // add wrapping to zero with carry: 4+5 (R3)
    checkOne(encNum(4), encNum(5), 2'b10, "R3 wrap");
    // reserved mode 0 and code 11 with carrying operands (R7)
    checkOne(encNum(8), encNum(8), 2'b00, "R7 mode0");
    checkOne(encNum(8), encNum(8), 2'b11, "R7 mode3");
    // illegal digit codes in X or Y, each mode (R8)
    checkOne(4'b1011, encNum(8), 2'b10, "R8 xlow add");
    checkOne(4'b1110, encNum(2), 2'b01, "R8 xhigh sub");
    checkOne(encNum(5), 4'b0011, 2'b10, "R8 ylow add");
    checkOne(encNum(5), 4'b1100, 2'b01, "R8 yhigh sub");
    checkOne(4'b1111, 4'b1111, 2'b01, "R8 all bad");
    // recovery after error (R9)
    checkOne(encNum(7), encNum(3), 2'b01, "R9 recover");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule